// File: doc/BRIEF.md
# DMA Channel Start Gate

This block holds the register state of a seven-slot DMA controller and decides the moment a channel transfer begins. Each channel has three 32-bit registers: a memory address, a block count and a control word. One shared enable register holds one enable bit per channel. A bus master writes these registers through a single write port. Any register can be read back through a combinational read port.

A transfer starts only when software writes a channel's control word. If the written word has its busy bit set and that channel's enable bit is set, the block pulses that channel's start strobe for one cycle. With the strobe it presents the channel's stored address and count and the control word just written. The transfer engine raises a done pulse when it finishes, and that pulse clears the busy bit. A control write that sets the busy bit again while the channel is still busy counts as a re-trigger. It raises a sticky diagnostic flag and starts nothing. Slot 5 is absent.

Top module: `dmaStartGate`

## Requirements
- R1: After reset every register reads zero, no start strobe is high and no re-trigger flag is set.
- R2: Channel n (n = 0..6, n != 5) stores its address, count and control words at byte addresses 0x080 + 0x10*n, +4 and +8. The shared enable register is at 0x0F0. Each written value reads back unchanged from the same address in the cycle after the write.
- R3: A write to channel n's control word with bit 24 set, while bit (3 + 4*n) of the enable register is set and the channel is not being re-triggered, drives startStb[n] high for exactly the cycle after the write edge. In that cycle startAddr and startCount equal the channel's stored address and count, and startCtrl equals the written control word.
- R4: A control write with bit 24 clear, or with the channel's enable bit clear, starts nothing. The written value is still stored.
- R5: A write to the enable register never produces a start by itself, even for channels whose stored bit 24 is set.
- R6: A control write with bit 24 set, to a channel whose stored bit 24 is set and that gets no done pulse in the same cycle, sets retrigFlag[n]. The flag holds until reset. No start occurs, and the written value is still stored.
- R7: A doneIn[n] pulse clears bit 24 of channel n's control word and leaves the other bits alone. A control write to the same channel in the same cycle wins over the pulse.
- R8: Slot 5 has no registers. Its addresses read zero, writes to them are ignored, and it never starts or flags.
- R9: Any address that maps to no register reads zero, and writes to it change no register.
- R10: At most one start strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 12 | Write byte address |
| wrData | input | 32 | Write data |
| rdAddr | input | 12 | Read byte address |
| rdData | output | 32 | Read data, combinational |
| doneIn | input | 7 | Per-channel transfer-complete pulse |
| startStb | output | 7 | Per-channel one-cycle start strobe |
| startAddr | output | 32 | Address given with the start |
| startCount | output | 32 | Block count given with the start |
| startCtrl | output | 32 | Control word given with the start |
| retrigFlag | output | 7 | Sticky per-channel re-trigger flag |

## Verification
Stored values, the effect of done pulses and re-trigger flags take effect at the clock edge that samples the write. The start strobe and its payload are registered at that same edge. So every result is due in the cycle after the stimulus. Reads are combinational on the current state. The bench drives inputs at the falling edge. It checks the read data 1 ns later against its model of the state before the coming edge. At the next falling edge it checks the strobe, the payload and the flags that the model predicted from the previous cycle's inputs.

// File: rtl/dmaGatePkg.sv
`timescale 1ns/1ps
package dmaGatePkg;
  localparam int GATE_CH = 7;

  typedef struct packed {
    logic [GATE_CH-1:0] wrAddr;
    logic [GATE_CH-1:0] wrCount;
    logic [GATE_CH-1:0] wrCtrl;
    logic               wrEnable;
    logic [GATE_CH-1:0] launch;
  } gateStb_t;
endpackage

// File: rtl/dmaGateCtrl.sv
`timescale 1ns/1ps
module dmaGateCtrl
  import dmaGatePkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int BUSY_BIT   = 24,
  parameter int SKIP_CH    = 5,
  parameter int BASE_ADDR  = 'h080,
  parameter int STRIDE     = 'h10,
  parameter int ENREG_ADDR = 'h0F0,
  parameter int EN_OFS     = 3,
  parameter int EN_STEP    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [GATE_CH-1:0] doneIn,
  input  logic [GATE_CH-1:0] busyVec,
  input  logic [DATA_W-1:0]  enReg,
  output gateStb_t           stb,
  output logic [GATE_CH-1:0] retrigFlag
);
  localparam int NCH = GATE_CH;
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(ENREG_ADDR);

  logic [NCH-1:0] addrHit, countHit, ctrlHit, retrigHit, launchHit;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : gDec
      if (g == SKIP_CH) begin : gAbsent
        assign addrHit[g]   = 1'b0;
        assign countHit[g]  = 1'b0;
        assign ctrlHit[g]   = 1'b0;
        assign retrigHit[g] = 1'b0;
        assign launchHit[g] = 1'b0;
      end else begin : gPresent
        localparam logic [ADDR_W-1:0] CH_BASE = ADDR_W'(BASE_ADDR + STRIDE * g);
        assign addrHit[g]   = wrEn && (wrAddr == CH_BASE);
        assign countHit[g]  = wrEn && (wrAddr == CH_BASE + ADDR_W'(4));
        assign ctrlHit[g]   = wrEn && (wrAddr == CH_BASE + ADDR_W'(8));
        assign retrigHit[g] = ctrlHit[g] && wrData[BUSY_BIT] && busyVec[g] && !doneIn[g];
        assign launchHit[g] = ctrlHit[g] && wrData[BUSY_BIT] &&
                              enReg[EN_OFS + EN_STEP * g] && !retrigHit[g];
      end
    end
  endgenerate

  assign stb = '{wrAddr:   addrHit,
                 wrCount:  countHit,
                 wrCtrl:   ctrlHit,
                 wrEnable: wrEn && (wrAddr == EN_ADDR),
                 launch:   launchHit};

  always_ff @(posedge clk) begin
    if (!rstN) retrigFlag <= '0;
    else       retrigFlag <= retrigFlag | retrigHit;
  end

  generate
    for (g = 0; g < NCH; g++) begin : gChk
      // R6: a raised re-trigger flag never drops while out of reset
      a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
        retrigFlag[g] |=> retrigFlag[g]);
    end
  endgenerate

  // R5: a write to the enable register never coincides with a launch decision
  a_r5_enable_no_launch: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == EN_ADDR) |-> (launchHit == '0));

endmodule

// File: rtl/dmaGateRegs.sv
`timescale 1ns/1ps
module dmaGateRegs
  import dmaGatePkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int BUSY_BIT   = 24,
  parameter int SKIP_CH    = 5,
  parameter int BASE_ADDR  = 'h080,
  parameter int STRIDE     = 'h10,
  parameter int ENREG_ADDR = 'h0F0,
  parameter int EN_OFS     = 3,
  parameter int EN_STEP    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStb_t           stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [GATE_CH-1:0] doneIn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [GATE_CH-1:0] busyVec,
  output logic [DATA_W-1:0]  enReg,
  output logic [GATE_CH-1:0] startStb,
  output logic [DATA_W-1:0]  startAddr,
  output logic [DATA_W-1:0]  startCount,
  output logic [DATA_W-1:0]  startCtrl
);
  localparam int NCH = GATE_CH;
  localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;

  logic [DATA_W-1:0] addrReg  [NCH];
  logic [DATA_W-1:0] countReg [NCH];
  logic [DATA_W-1:0] ctrlReg  [NCH];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : gCh
      if (g == SKIP_CH) begin : gAbsent
        assign addrReg[g]  = '0;
        assign countReg[g] = '0;
        assign ctrlReg[g]  = '0;
      end else begin : gPresent
        always_ff @(posedge clk) begin
          if (!rstN) begin
            addrReg[g]  <= '0;
            countReg[g] <= '0;
            ctrlReg[g]  <= '0;
          end else begin
            if (stb.wrAddr[g])  addrReg[g]  <= wrData;
            if (stb.wrCount[g]) countReg[g] <= wrData;
            if (stb.wrCtrl[g])  ctrlReg[g]  <= wrData;
            else if (doneIn[g]) ctrlReg[g]  <= ctrlReg[g] & ~BUSY_MASK;
          end
        end

        // R7: a done pulse with no competing control write leaves the channel idle
        a_r7_done_clears: assert property (@(posedge clk) disable iff (!rstN)
          (doneIn[g] && !stb.wrCtrl[g]) |=> !ctrlReg[g][BUSY_BIT]);
        // R3: a start is only seen on a channel whose stored word is busy
        a_r3_start_busy: assert property (@(posedge clk) disable iff (!rstN)
          startStb[g] |-> ctrlReg[g][BUSY_BIT]);
        // R3: a start is only seen on an enabled channel
        a_r3_start_enabled: assert property (@(posedge clk) disable iff (!rstN)
          startStb[g] |-> enReg[EN_OFS + EN_STEP * g]);
      end
      assign busyVec[g] = ctrlReg[g][BUSY_BIT];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) enReg <= '0;
    else if (stb.wrEnable) enReg <= wrData;
  end

  logic [DATA_W-1:0] launchAddr, launchCount;
  always_comb begin
    launchAddr  = '0;
    launchCount = '0;
    for (int n = 0; n < NCH; n++) begin
      if (stb.launch[n]) begin
        launchAddr  = launchAddr  | addrReg[n];
        launchCount = launchCount | countReg[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startStb   <= '0;
      startAddr  <= '0;
      startCount <= '0;
      startCtrl  <= '0;
    end else begin
      startStb <= stb.launch;
      if (stb.launch != '0) begin
        startAddr  <= launchAddr;
        startCount <= launchCount;
        startCtrl  <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(ENREG_ADDR)) rdData = enReg;
    for (int n = 0; n < NCH; n++) begin
      if (rdAddr == ADDR_W'(BASE_ADDR + STRIDE * n))     rdData = addrReg[n];
      if (rdAddr == ADDR_W'(BASE_ADDR + STRIDE * n + 4)) rdData = countReg[n];
      if (rdAddr == ADDR_W'(BASE_ADDR + STRIDE * n + 8)) rdData = ctrlReg[n];
    end
  end

  // R10: never more than one channel started in a cycle
  a_r10_single_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startStb));
  // R8: the absent slot never starts
  a_r8_absent_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !startStb[SKIP_CH]);

endmodule

// File: rtl/dmaStartGate.sv
`timescale 1ns/1ps
module dmaStartGate
  import dmaGatePkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int BUSY_BIT   = 24,
  parameter int SKIP_CH    = 5,
  parameter int BASE_ADDR  = 'h080,
  parameter int STRIDE     = 'h10,
  parameter int ENREG_ADDR = 'h0F0,
  parameter int EN_OFS     = 3,
  parameter int EN_STEP    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [GATE_CH-1:0] doneIn,
  output logic [GATE_CH-1:0] startStb,
  output logic [DATA_W-1:0]  startAddr,
  output logic [DATA_W-1:0]  startCount,
  output logic [DATA_W-1:0]  startCtrl,
  output logic [GATE_CH-1:0] retrigFlag
);
  gateStb_t          stb;
  logic [GATE_CH-1:0] busyVec;
  logic [DATA_W-1:0]  enReg;

  dmaGateCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT), .SKIP_CH(SKIP_CH),
    .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE), .ENREG_ADDR(ENREG_ADDR),
    .EN_OFS(EN_OFS), .EN_STEP(EN_STEP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .doneIn(doneIn), .busyVec(busyVec), .enReg(enReg),
    .stb(stb), .retrigFlag(retrigFlag)
  );

  dmaGateRegs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT), .SKIP_CH(SKIP_CH),
    .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE), .ENREG_ADDR(ENREG_ADDR),
    .EN_OFS(EN_OFS), .EN_STEP(EN_STEP)
  ) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .doneIn(doneIn),
    .rdAddr(rdAddr), .rdData(rdData), .busyVec(busyVec), .enReg(enReg),
    .startStb(startStb), .startAddr(startAddr), .startCount(startCount),
    .startCtrl(startCtrl)
  );
endmodule

// File: tb/tb_dmaStartGate.sv
`timescale 1ns/1ps
module tb_dmaStartGate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [6:0]  doneIn = '0;
  logic [6:0]  startStb;
  logic [31:0] startAddr, startCount, startCtrl;
  logic [6:0]  retrigFlag;

  always #5 clk = ~clk;

  dmaStartGate dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .doneIn(doneIn), .startStb(startStb),
    .startAddr(startAddr), .startCount(startCount), .startCtrl(startCtrl),
    .retrigFlag(retrigFlag)
  );

  int tests = 0;
  int fails = 0;

  // reference model
  logic [31:0] mAddr [7];
  logic [31:0] mCount[7];
  logic [31:0] mCtrl [7];
  logic [31:0] mEn;
  logic [6:0]  mRetrig;
  logic [6:0]  expStart;
  logic [31:0] expSA, expSC, expSCtl;
  string       expTag;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // returns 1 for a channel register; ch and sub set
  function automatic bit decode(input logic [11:0] a, output int ch, output int sub);
    ch = 0; sub = 0;
    if (a < 12'h080 || a >= 12'h0F0) return 0;
    ch  = int'((a - 12'h080) >> 4);
    sub = int'(a[3:0]);
    return (ch != 5) && (sub == 0 || sub == 4 || sub == 8);
  endfunction

  function automatic logic [31:0] rdModel(input logic [11:0] a);
    int ch, sub;
    if (a == 12'h0F0) return mEn;
    if (!decode(a, ch, sub)) return 32'h0;
    if (sub == 0) return mAddr[ch];
    if (sub == 4) return mCount[ch];
    return mCtrl[ch];
  endfunction

  // one cycle: check last cycle's results, drive, check read, advance model
  task automatic step(input bit we, input logic [11:0] wa, input logic [31:0] wd,
                      input logic [11:0] ra, input logic [6:0] dn);
    int ch, sub;
    bit isCh;
    check({"R3/R4/R5/R6/R8 startStb ", expTag}, {25'h0, startStb}, {25'h0, expStart});
    if (expStart != '0) begin
      check("R3 startAddr", startAddr, expSA);
      check("R3 startCount", startCount, expSC);
      check("R3 startCtrl", startCtrl, expSCtl);
    end
    check("R6 retrigFlag", {25'h0, retrigFlag}, {25'h0, mRetrig});
    wrEn = we; wrAddr = wa; wrData = wd; rdAddr = ra; doneIn = dn;
    #1;
    check("R2/R7/R8/R9 rdData", rdData, rdModel(ra));
    expStart = '0;
    expTag = "idle";
    isCh = decode(wa, ch, sub);
    // R7: done clears bit 24 unless overridden by a control write
    for (int n = 0; n < 7; n++)
      if (n != 5 && dn[n] && !(we && isCh && sub == 8 && ch == n)) mCtrl[n][24] = 1'b0;
    if (we && wa == 12'h0F0) begin
      mEn = wd;
      expTag = "R5 enable write";
    end else if (we && isCh) begin
      if (sub == 0) mAddr[ch] = wd;
      else if (sub == 4) mCount[ch] = wd;
      else begin
        if (wd[24] && mCtrl[ch][24] && !dn[ch]) begin
          mRetrig[ch] = 1'b1;
          expTag = "R6 retrigger";
        end else if (wd[24] && mEn[3 + 4 * ch]) begin
          expStart[ch] = 1'b1;
          expSA = mAddr[ch]; expSC = mCount[ch]; expSCtl = wd;
          expTag = "R3 launch";
        end else expTag = "R4 no launch";
        mCtrl[ch] = wd;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [11:0] chAddr(input int ch, input int sub);
    return 12'(12'h080 + 16 * ch + sub);
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 7; n++) begin mAddr[n] = 0; mCount[n] = 0; mCtrl[n] = 0; end
    mEn = 0; mRetrig = 0; expStart = 0; expSA = 0; expSC = 0; expSCtl = 0; expTag = "reset";
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 startStb", {25'h0, startStb}, 32'h0);
    check("R1 retrigFlag", {25'h0, retrigFlag}, 32'h0);
    for (int n = 0; n < 7; n++) step(0, 0, 0, chAddr(n, 8), 0);
    step(0, 0, 0, 12'h0F0, 0);

    // R2: store address/count on channel 2, enable channel 2 (bit 11)
    step(1, chAddr(2, 0), 32'h1000_0040, chAddr(2, 0), 0);
    step(1, chAddr(2, 4), 32'h0001_0010, chAddr(2, 0), 0);
    step(1, 12'h0F0, 32'h0000_0800, chAddr(2, 4), 0);
    // R3: launch
    step(1, chAddr(2, 8), 32'h0100_0201, 12'h0F0, 0);
    // R6: retrigger while busy
    step(1, chAddr(2, 8), 32'h0100_0003, chAddr(2, 8), 0);
    // R7: done clears bit 24, then relaunch allowed
    step(0, 0, 0, chAddr(2, 8), 7'b0000100);
    step(1, chAddr(2, 8), 32'h0100_0005, chAddr(2, 8), 0);
    // R4: channel 0 not enabled -> no launch, but stored
    step(1, chAddr(0, 8), 32'h0100_0000, chAddr(0, 8), 0);
    // R5: enabling channel 0 with bit 24 pending does not launch
    step(1, 12'h0F0, 32'h0000_0808, chAddr(0, 8), 0);
    step(0, 0, 0, chAddr(0, 8), 0);
    // R8: slot 5 writes ignored
    step(1, chAddr(5, 0), 32'hdead_beef, chAddr(5, 0), 0);
    step(1, chAddr(5, 8), 32'h0100_0000, chAddr(5, 0), 0);
    step(0, 0, 0, chAddr(5, 8), 0);
    // R9: unmapped address write/read
    step(1, 12'h0BC, 32'h1234_5678, 12'h0BC, 0);
    step(1, 12'h300, 32'h1234_5678, 12'h300, 0);
    // R7: done and control write same cycle -> write wins (channel 6 enable bit 27)
    step(1, 12'h0F0, 32'h0800_0808, 12'h0F0, 0);
    step(1, chAddr(6, 8), 32'h0100_0000, chAddr(6, 8), 0);
    step(1, chAddr(6, 8), 32'h0100_00ff, chAddr(6, 8), 7'b1000000);
    step(0, 0, 0, chAddr(6, 8), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int ch, sub, kind;
      logic [11:0] wa, ra;
      logic [31:0] wd;
      logic [6:0] dn;
      kind = int'($urandom_range(0, 9));
      ch   = int'($urandom_range(0, 6));
      sub  = 4 * int'($urandom_range(0, 3));
      wa   = chAddr(ch, sub);
      wd   = $urandom;
      if (kind < 5) begin wa = chAddr(ch, 8); wd[24] = ($urandom_range(0, 9) < 6); end
      else if (kind == 5) wa = 12'h0F0;
      else if (kind == 6) wa = 12'($urandom_range(0, 4095));
      ra   = ($urandom_range(0, 7) == 0) ? 12'h0F0 : chAddr(int'($urandom_range(0, 6)), 4 * int'($urandom_range(0, 3)));
      dn   = ($urandom_range(0, 3) == 0) ? 7'(1 << $urandom_range(0, 6)) : 7'h0;
      step(kind != 9, wa, wd, ra, dn);
    end
    step(0, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule